// File: doc/BRIEF.md
# Ingress Length Check and Short-Frame Padding

This block sits on the host-to-port ingress path, after the sideband words of a packet have been parsed. It receives the packet as a stream of bytes with start and end markers, counts the bytes, and keeps the whole packet in a local buffer until its final byte has been seen. Only then does it decide what to do with the packet. A packet that is too long is discarded. A packet that is too short is either padded with zero bytes up to the Ethernet minimum or discarded. A packet whose host-supplied CRC is flagged bad is either forwarded with its CRC visibly corrupted or discarded.

Two sideband flags travel with the packet. One says whether the host has appended the CRC to the data. The other, valid on the last byte, says that this appended CRC is known to be wrong. Three configuration inputs set the policy: the maximum accepted length, whether short packets without a CRC may be padded, and whether packets with a bad CRC are forwarded in marked form. A forwarded packet is sent as one contiguous burst on the output. A discarded packet produces a one-cycle drop pulse instead.

Top module: `ingress_len_pad`

## Requirements
- R1: `in_ready` is high whenever no packet is being sent and low while one is being sent. No output byte appears before the final byte of its packet has been accepted.
- R2: A packet whose byte count exceeds `cfg_max_len` is discarded. A packet exactly `cfg_max_len` bytes long is forwarded.
- R3: A packet longer than the buffer depth `DEPTH` (2048 bytes by default) is discarded, even when `cfg_max_len` would allow it. A packet of exactly `DEPTH` bytes is forwarded.
- R4: With the pass-CRC flag clear and `cfg_pad_en` set, a packet of fewer than 60 bytes is sent as 60 bytes: its own bytes followed by zero bytes. A packet of 60 bytes or more is sent unchanged.
- R5: With the pass-CRC flag clear and `cfg_pad_en` clear, a packet of fewer than 60 bytes is discarded.
- R6: With the pass-CRC flag set, a packet of fewer than 64 bytes is discarded, whatever `cfg_pad_en` holds. A packet of 64 bytes is forwarded.
- R7: With the pass-CRC flag set, `in_crc_bad` set on the last byte and `cfg_bad_crc_fwd` set, the packet is forwarded with its final byte bit-inverted and every other byte unchanged.
- R8: With the pass-CRC flag set, `in_crc_bad` set on the last byte and `cfg_bad_crc_fwd` clear, the packet is discarded.
- R9: A forwarded packet starts in the cycle after its final byte is accepted. `out_valid` stays high for one cycle per output byte, `out_sop` marks the first byte and `out_eop` marks the last. `out_valid` is low in the cycle after `out_eop`.
- R10: After reset, `in_ready` is 1 and both `out_valid` and `out_drop` are 0.
- R11: The pass-CRC flag is taken from the start-of-packet byte only, and `in_crc_bad` is taken from the end-of-packet byte only. `in_crc_bad` has no effect when the pass-CRC flag is clear.
- R12: Each discarded packet raises `out_drop` for exactly one cycle, in the cycle after its final byte is accepted. No output bytes are produced for that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_max_len | input | LEN_W | Largest accepted packet length, in bytes |
| cfg_pad_en | input | 1 | Allow zero padding of short packets that carry no CRC |
| cfg_bad_crc_fwd | input | 1 | Forward packets with a bad passed CRC in marked form instead of discarding them |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can accept an input byte |
| in_data | input | DATA_W | Input byte |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_pass_crc | input | 1 | The packet carries its CRC (sampled with `in_sop`) |
| in_crc_bad | input | 1 | The passed CRC is bad (sampled with `in_eop`) |
| out_valid | output | 1 | Output byte valid |
| out_data | output | DATA_W | Output byte |
| out_sop | output | 1 | First output byte of a packet |
| out_eop | output | 1 | Last output byte of a packet |
| out_drop | output | 1 | One-cycle pulse when a packet is discarded |

## Verification
The assertions assume a well-formed input stream. Every packet begins with a byte carrying `in_sop`, ends with a byte carrying `in_eop`, and is offered only while `in_ready` is high. The configuration inputs are assumed not to change while a packet's final byte is being accepted. The bench meets these assumptions by design. It waits for `in_ready` before each packet, marks the first and last beats explicitly, and changes the configuration only between packets, while the block is idle. Within those limits it inserts idle gaps inside packets. It also drives the opposite value of the pass-CRC flag on non-start beats, and the opposite value of the bad-CRC flag on non-end beats, so that the block's choice of which beat to sample is exercised.

// File: rtl/ilp_pkg.sv
package ilp_pkg;

  typedef enum logic [2:0] {
    VD_FWD,
    VD_PAD,
    VD_MARK,
    VD_DROP_LONG,
    VD_DROP_SHORT,
    VD_DROP_CRC
  } verdict_e;

  localparam int unsigned MIN_NO_CRC   = 60;
  localparam int unsigned MIN_WITH_CRC = 64;

  // Final decision for one packet from its length and flags.
  function automatic verdict_e judge(input int unsigned len,
                                     input int unsigned max_len,
                                     input int unsigned depth,
                                     input logic pass_crc,
                                     input logic crc_bad,
                                     input logic pad_en,
                                     input logic bad_fwd);
    if (len > max_len || len > depth) return VD_DROP_LONG;
    if (pass_crc) begin
      if (len < MIN_WITH_CRC) return VD_DROP_SHORT;
      if (crc_bad) return bad_fwd ? VD_MARK : VD_DROP_CRC;
      return VD_FWD;
    end
    if (len < MIN_NO_CRC) return pad_en ? VD_PAD : VD_DROP_SHORT;
    return VD_FWD;
  endfunction

  function automatic logic is_drop(input verdict_e v);
    return (v == VD_DROP_LONG) || (v == VD_DROP_SHORT) || (v == VD_DROP_CRC);
  endfunction

  // Number of bytes put on the output for a forwarded packet.
  function automatic int unsigned wire_len(input int unsigned len, input verdict_e v);
    return (v == VD_PAD) ? MIN_NO_CRC : len;
  endfunction

endpackage

// File: rtl/ilp_len_track.sv
module ilp_len_track #(
  parameter int unsigned LEN_W = 14,
  parameter int unsigned DEPTH = 2048,
  localparam int unsigned CNT_W = LEN_W + 1,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             sop,
  input  logic             eop,
  input  logic             pass_in,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic             done,
  output logic [CNT_W-1:0] done_len,
  output logic             done_pass
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic             pass_q;

  always_comb begin
    base      = sop ? '0 : cnt_q;
    wr_en     = beat && (32'(base) < DEPTH);
    wr_addr   = base[AW-1:0];
    done_len  = (base == CNT_MAX) ? CNT_MAX : base + 1'b1;
    done      = beat && eop;
    done_pass = sop ? pass_in : pass_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pass_q <= 1'b0;
    end else if (beat) begin
      cnt_q <= done_len;
      if (sop) pass_q <= pass_in;
    end
  end

  // R11
  pass_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !sop |=> pass_q == $past(pass_q));

endmodule

// File: rtl/ilp_byte_store.sv
module ilp_byte_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 2048,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/ilp_tx_seq.sv
module ilp_tx_seq #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 15,
  parameter int unsigned AW     = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  start_tx_len,
  input  logic [CNT_W-1:0]  start_src_len,
  input  logic              start_mark,
  output logic [AW-1:0]     rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              busy
);

  logic             active_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] tx_len_q;
  logic [CNT_W-1:0] src_len_q;
  logic             mark_q;

  logic pad_zone;
  logic last_src;
  logic last_tx;

  assign pad_zone = idx_q >= src_len_q;
  assign last_src = idx_q == (src_len_q - 1'b1);
  assign last_tx  = idx_q == (tx_len_q - 1'b1);
  assign rd_addr  = idx_q[AW-1:0];

  always_comb begin
    out_valid = active_q;
    out_sop   = active_q && (idx_q == '0);
    out_eop   = active_q && last_tx;
    busy      = active_q;
    if (pad_zone)              out_data = '0;
    else if (mark_q && last_src) out_data = ~rd_data;
    else                       out_data = rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      idx_q     <= '0;
      tx_len_q  <= '0;
      src_len_q <= '0;
      mark_q    <= 1'b0;
    end else if (start) begin
      active_q  <= 1'b1;
      idx_q     <= '0;
      tx_len_q  <= start_tx_len;
      src_len_q <= start_src_len;
      mark_q    <= start_mark;
    end else if (active_q) begin
      if (last_tx) active_q <= 1'b0;
      else         idx_q    <= idx_q + 1'b1;
    end
  end

  // R1
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active_q);

  // R9
  eop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eop |=> !out_valid);

  // R9
  sop_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sop);

endmodule

// File: rtl/ingress_len_pad.sv
module ingress_len_pad
  import ilp_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned LEN_W  = 14,
  parameter int unsigned DEPTH  = 2048
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEN_W-1:0]  cfg_max_len,
  input  logic              cfg_pad_en,
  input  logic              cfg_bad_crc_fwd,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_pass_crc,
  input  logic              in_crc_bad,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_drop
);

  localparam int unsigned CNT_W = LEN_W + 1;
  localparam int unsigned AW    = $clog2(DEPTH);

  logic             beat;
  logic             wr_en;
  logic [AW-1:0]    wr_addr;
  logic [AW-1:0]    rd_addr;
  logic [DATA_W-1:0] rd_data;
  logic             done;
  logic [CNT_W-1:0] done_len;
  logic             done_pass;
  logic             tx_busy;
  verdict_e         verdict;
  logic             drop_evt;
  logic             start_evt;
  logic [CNT_W-1:0] tx_len;
  logic             drop_q;

  assign in_ready = !tx_busy;
  assign beat     = in_valid && in_ready;

  ilp_len_track #(.LEN_W(LEN_W), .DEPTH(DEPTH)) u_track (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sop(in_sop), .eop(in_eop),
    .pass_in(in_pass_crc), .wr_en(wr_en), .wr_addr(wr_addr),
    .done(done), .done_len(done_len), .done_pass(done_pass)
  );

  ilp_byte_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_data),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always_comb begin
    verdict   = judge(32'(done_len), 32'(cfg_max_len), DEPTH, done_pass,
                      in_crc_bad, cfg_pad_en, cfg_bad_crc_fwd);
    drop_evt  = done && is_drop(verdict);
    start_evt = done && !is_drop(verdict);
    tx_len    = CNT_W'(wire_len(32'(done_len), verdict));
  end

  ilp_tx_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W), .AW(AW)) u_tx (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .start_tx_len(tx_len),
    .start_src_len(done_len), .start_mark(verdict == VD_MARK),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_valid(out_valid),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop), .busy(tx_busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) drop_q <= 1'b0;
    else        drop_q <= drop_evt;
  end
  assign out_drop = drop_q;

  // R1
  hold_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R2
  long_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && (32'(done_len) > 32'(cfg_max_len)) |=> out_drop && !out_valid);

  // R5
  nopad_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_pass && !cfg_pad_en && (32'(done_len) < 60) |=> out_drop);

  // R6
  short_crc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_pass && (32'(done_len) < 64) |=> out_drop);

  // R8
  bad_crc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && done_pass && in_crc_bad && !cfg_bad_crc_fwd |=> out_drop);

  // R12
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_drop |-> !out_valid && !$past(out_drop));

endmodule

// File: tb/ingress_len_pad_test.sv
module ingress_len_pad_test;

  localparam int DEPTH = 2048;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n;
  logic [13:0] cfg_max_len;
  logic        cfg_pad_en;
  logic        cfg_bad_crc_fwd;
  logic        in_valid;
  logic        in_ready;
  logic [7:0]  in_data;
  logic        in_sop;
  logic        in_eop;
  logic        in_pass_crc;
  logic        in_crc_bad;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_sop;
  logic        out_eop;
  logic        out_drop;

  ingress_len_pad uut (
    .clk(clk), .rst_n(rst_n), .cfg_max_len(cfg_max_len), .cfg_pad_en(cfg_pad_en),
    .cfg_bad_crc_fwd(cfg_bad_crc_fwd), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sop(in_sop), .in_eop(in_eop), .in_pass_crc(in_pass_crc),
    .in_crc_bad(in_crc_bad), .out_valid(out_valid), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .out_drop(out_drop)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit mon_en = 0;
  bit drop_pend = 0;
  string cur_tag = "R9";

  byte unsigned eq_data[$];
  bit           eq_sop[$];
  bit           eq_eop[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference model: decide and queue the expected output at the final beat.
  task automatic model(input byte unsigned pk[$], input bit pass, input bit bad,
                       input string tag);
    int  len  = pk.size();
    int  outn = len;
    bit  drop = 0;
    bit  mark = 0;
    if (len > int'(cfg_max_len) || len > DEPTH) drop = 1;
    else if (pass) begin
      if (len < 64) drop = 1;
      else if (bad) begin
        if (cfg_bad_crc_fwd) mark = 1;
        else drop = 1;
      end
    end else if (len < 60) begin
      if (cfg_pad_en) outn = 60;
      else drop = 1;
    end
    cur_tag = tag;
    if (drop) drop_pend = 1;
    else begin
      for (int i = 0; i < outn; i++) begin
        byte unsigned b;
        b = (i < len) ? pk[i] : 8'h00;
        if (mark && i == len - 1) b = ~b;
        eq_data.push_back(b);
        eq_sop.push_back(i == 0);
        eq_eop.push_back(i == outn - 1);
      end
    end
  endtask

  task automatic send(input int len, input bit pass, input bit bad,
                      input int seed, input int gap, input string tag);
    byte unsigned pk[$];
    for (int i = 0; i < len; i++) pk.push_back(8'((seed + i * 7) & 255));
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      in_valid    = 1'b1;
      in_data     = pk[i];
      in_sop      = (i == 0);
      in_eop      = (i == len - 1);
      in_pass_crc = (i == 0) ? pass : !pass;          // R11 sampled on start only
      in_crc_bad  = (i == len - 1) ? bad : !bad;      // R11 sampled on end only
      @(posedge clk);
      if (i == len - 1) model(pk, pass, bad, tag);
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
      in_eop   = 1'b0;
      if (gap > 0 && (i % 5) == 2) repeat (gap - 1) @(negedge clk);
    end
  endtask

  task automatic drain();
    @(negedge clk);
    while (eq_data.size() > 0 || !in_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Per-clock comparison against the model.
  always @(negedge clk) begin
    if (mon_en) begin
      bit ev;
      ev = eq_data.size() > 0;
      chk(out_valid == ev, cur_tag, "out_valid", int'(out_valid), int'(ev));
      chk(in_ready == !ev, "R1", "in_ready", int'(in_ready), int'(!ev));
      if (out_valid && ev) begin
        byte unsigned d;
        bit s, e;
        d = eq_data.pop_front();
        s = eq_sop.pop_front();
        e = eq_eop.pop_front();
        chk(out_data == d, cur_tag, "out_data", int'(out_data), int'(d));
        chk(out_sop == s, "R9", "out_sop", int'(out_sop), int'(s));
        chk(out_eop == e, "R9", "out_eop", int'(out_eop), int'(e));
      end
      chk(out_drop == drop_pend, "R12", "out_drop", int'(out_drop), int'(drop_pend));
      drop_pend = 0;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cfg_max_len = 14'd1000;
    cfg_pad_en = 1'b1;
    cfg_bad_crc_fwd = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    in_sop = 1'b0;
    in_eop = 1'b0;
    in_pass_crc = 1'b0;
    in_crc_bad = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(in_ready == 1'b1, "R10", "in_ready", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R10", "out_valid", int'(out_valid), 0);
    chk(out_drop == 1'b0, "R10", "out_drop", int'(out_drop), 0);
    mon_en = 1;

    // R9 plain forwarding, with and without gaps
    send(80, 0, 0, 3, 2, "R9");
    send(75, 1, 0, 11, 0, "R9");
    drain();
    // R11 bad flag ignored without passed CRC
    send(70, 0, 1, 21, 0, "R11");
    drain();
    // R2 max length boundary
    cfg_max_len = 14'd100;
    send(101, 0, 0, 5, 0, "R2");
    send(100, 0, 0, 6, 1, "R2");
    send(101, 1, 0, 7, 0, "R2");
    drain();
    // R4 padding
    cfg_pad_en = 1'b1;
    send(10, 0, 0, 40, 0, "R4");
    send(59, 0, 0, 41, 3, "R4");
    send(60, 0, 0, 42, 0, "R4");
    send(1, 0, 0, 43, 0, "R4");
    drain();
    // R5 no padding allowed
    cfg_pad_en = 1'b0;
    send(59, 0, 0, 50, 0, "R5");
    send(1, 0, 0, 51, 0, "R5");
    send(60, 0, 0, 52, 0, "R5");
    drain();
    // R6 passed CRC short packets
    send(63, 1, 0, 60, 0, "R6");
    cfg_pad_en = 1'b1;
    send(63, 1, 0, 61, 0, "R6");
    send(20, 1, 0, 62, 0, "R6");
    send(64, 1, 0, 63, 0, "R6");
    drain();
    // R7 bad CRC forwarded marked
    cfg_bad_crc_fwd = 1'b1;
    send(64, 1, 1, 70, 0, "R7");
    send(90, 1, 1, 71, 2, "R7");
    drain();
    // R8 bad CRC dropped
    cfg_bad_crc_fwd = 1'b0;
    send(90, 1, 1, 80, 0, "R8");
    send(64, 1, 1, 81, 0, "R8");
    send(90, 1, 0, 82, 0, "R8");
    drain();
    // R3 buffer depth boundary
    cfg_max_len = 14'h3FFF;
    send(DEPTH + 1, 0, 0, 90, 0, "R3");
    send(DEPTH, 0, 0, 91, 0, "R3");
    drain();

    mon_en = 0;
    finish_run();
  end

endmodule